// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital sequencer for an integrating analog-to-digital converter. The integrator, comparator and reference sit outside it. After a start request it steps through three analog phases. First it closes the offset-nulling switch. Next it switches the input signal onto the integrator for a fixed window. Last it switches the reference in, which ramps the integrator back down. The block measures how long that ramp-down takes, and the length of the ramp-down is the conversion result.

The integrate window is a parameter in clock cycles. It is meant to be set to a whole number of mains periods, for example 0.1 s, so that both 50 Hz and 60 Hz hum integrate to zero. A single counter times the offset-nulling phase, the integrate window and the measured ramp-down. The comparator bit passes through a two-stage synchronizer, and the two cycles of delay this adds are removed from the count. If the ramp-down runs past twice the integrate window, the result is reported as overrange.

Top module: `dsadc_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all three switch selects, busy_o, done_o and ovr_o are low and result_o is zero.
- R2: A start_i sampled high while idle raises sw_az_o from the next cycle, and sw_az_o stays high for exactly AZ_CYCLES cycles.
- R3: sw_in_o is high for exactly INT_CYCLES consecutive cycles in each conversion.
- R4: At most one switch select is high in any cycle. Between the offset-nulling and input phases, and between the input and reference phases, there is exactly one cycle with all selects low.
- R5: The result is N, the number of clock cycles from the first sw_ref_o cycle up to the first cycle in which the raw comparator input is low (comparator low means the integrator is at or below the threshold). A zero input gives 0.
- R6: If N would exceed 2*INT_CYCLES, the reference phase ends, ovr_o is set and result_o is all ones (127 with the default parameters). A result of exactly 2*INT_CYCLES is not overrange.
- R7: done_o is a one-cycle pulse. result_o and ovr_o take their new values in that same cycle and hold them until the next done_o pulse.
- R8: busy_o is high from the cycle after an accepted start through the done_o cycle, and low in the cycle after done_o.
- R9: A start_i pulse received while busy_o is high changes neither the phase timing nor the result, and does not queue a second conversion.
- R10: result_o is RES_W = ceil(log2(2*INT_CYCLES+3)) bits wide. This is 7 bits with the default INT_CYCLES of 40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, acted on only while idle |
| cmp_i | input | 1 | Asynchronous comparator bit: high while the integrator is above the threshold |
| sw_az_o | output | 1 | Select for the offset-nulling switch |
| sw_in_o | output | 1 | Select for the input-signal switch |
| sw_ref_o | output | 1 | Select for the reference switch |
| busy_o | output | 1 | A conversion is in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| ovr_o | output | 1 | The last conversion was overrange |
| result_o | output | RES_W | Ramp-down count of the last conversion |

## Verification
The hardest cases to reach from the ports are the edges of the ramp-down count. The first is the boundary where the comparator falls exactly on the last allowed cycle, so the result is 2*INT_CYCLES and not overrange. The second is the zero-input case, where the comparator is already low before the synchronizer has filled. The bench contains a behavioural integrator. It adds the input value on every input-phase cycle and subtracts a fixed reference step on every reference-phase cycle. The input values are chosen so that the crossing lands on those exact cycles. A start pulse issued in the middle of the offset-nulling phase checks that a second request neither stretches the phases nor queues a conversion.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AZ,
    ST_GAP_AI,
    ST_INT,
    ST_GAP_ID,
    ST_DEINT,
    ST_DONE
  } state_e;

  localparam int unsigned SYNC_LAT = 2;
endpackage

// File: rtl/dsadc_sync2.sv
module dsadc_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[0], d_i};
  end

  assign q_o = stg_q[1];
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int unsigned AZ_CYCLES  = 8,
  parameter int unsigned INT_CYCLES = 40,
  parameter int unsigned CNT_W      = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_s_i,
  output state_e           state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o,
  output logic             over_o
);
  localparam int unsigned DEINT_MAX = 2 * INT_CYCLES + SYNC_LAT;

  state_e           state_q;
  logic [CNT_W-1:0] cnt_q;

  // measurement ends on the first low synchronized comparator, else at the limit
  assign hit_o  = (state_q == ST_DEINT) && !cmp_s_i;
  assign over_o = (state_q == ST_DEINT) && cmp_s_i && (cnt_q == CNT_W'(DEINT_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start_i) state_q <= ST_AZ;
        end
        ST_AZ: begin
          if (cnt_q == CNT_W'(AZ_CYCLES - 1)) begin
            state_q <= ST_GAP_AI;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_GAP_AI: begin
          state_q <= ST_INT;
          cnt_q   <= '0;
        end
        ST_INT: begin
          if (cnt_q == CNT_W'(INT_CYCLES - 1)) begin
            state_q <= ST_GAP_ID;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_GAP_ID: begin
          state_q <= ST_DEINT;
          cnt_q   <= '0;
        end
        ST_DEINT: begin
          if (hit_o || over_o) state_q <= ST_DONE;
          else                 cnt_q   <= cnt_q + 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/dsadc_result.sv
module dsadc_result #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned LAT   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             over_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] result_o,
  output logic             ovr_o
);
  logic [CNT_W-1:0] meas;

  // remove synchronizer latency; an early low (zero input) clamps to 0
  assign meas = (cnt_i >= CNT_W'(LAT)) ? cnt_i - CNT_W'(LAT) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      ovr_o    <= 1'b0;
    end else if (over_i) begin
      result_o <= '1;
      ovr_o    <= 1'b1;
    end else if (hit_i) begin
      result_o <= meas;
      ovr_o    <= 1'b0;
    end
  end
endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int unsigned AZ_CYCLES  = 8,
  parameter int unsigned INT_CYCLES = 40,
  localparam int unsigned DEINT_MAX = 2 * INT_CYCLES + SYNC_LAT,
  localparam int unsigned CNT_LIM   = (DEINT_MAX > AZ_CYCLES) ? DEINT_MAX : AZ_CYCLES,
  localparam int unsigned RES_W     = $clog2(CNT_LIM + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             sw_az_o,
  output logic             sw_in_o,
  output logic             sw_ref_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovr_o,
  output logic [RES_W-1:0] result_o
);
  logic             cmp_s;
  state_e           state;
  logic [RES_W-1:0] cnt;
  logic             hit, over;

  dsadc_sync2 u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  dsadc_seq #(
    .AZ_CYCLES (AZ_CYCLES),
    .INT_CYCLES(INT_CYCLES),
    .CNT_W     (RES_W)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .cmp_s_i(cmp_s),
    .state_o(state),
    .cnt_o  (cnt),
    .hit_o  (hit),
    .over_o (over)
  );

  dsadc_result #(
    .CNT_W(RES_W),
    .LAT  (SYNC_LAT)
  ) u_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .over_i  (over),
    .cnt_i   (cnt),
    .result_o(result_o),
    .ovr_o   (ovr_o)
  );

  // selects decode straight from the state register; gap states leave all off
  assign sw_az_o  = (state == ST_AZ);
  assign sw_in_o  = (state == ST_INT);
  assign sw_ref_o = (state == ST_DEINT);
  assign busy_o   = (state != ST_IDLE);
  assign done_o   = (state == ST_DONE);
endmodule

// File: rtl/dsadc_ctrl_chk.sv
module dsadc_ctrl_chk #(
  parameter int unsigned RES_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sw_az_o,
  input logic             sw_in_o,
  input logic             sw_ref_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             ovr_o,
  input logic [RES_W-1:0] result_o
);
  // R4
  sw_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sw_az_o, sw_in_o, sw_ref_o}));

  // R4
  gap_before_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_in_o) |-> !$past(sw_az_o));

  // R4
  gap_before_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_ref_o) |-> !$past(sw_in_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable(ovr_o)));

  // R6
  ovr_saturate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> (result_o == {RES_W{1'b1}}));

  // R8
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  // R8
  sw_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_az_o || sw_in_o || sw_ref_o) |-> busy_o);
endmodule

bind dsadc_ctrl dsadc_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sw_az_o (sw_az_o),
  .sw_in_o (sw_in_o),
  .sw_ref_o(sw_ref_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .ovr_o   (ovr_o),
  .result_o(result_o)
);

// File: tb/dsadc_ctrl_tb.sv
`timescale 1ns/1ps
module dsadc_ctrl_tb;
  localparam int AZ  = 8;
  localparam int INT = 40;
  localparam int REF_STEP = 16;
  localparam int W = 7;                  // R10: ceil(log2(2*40+3))
  localparam int NV = 8;
  localparam int VIN_T [NV] = '{0, 1, 3, 7, 20, 32, 33, 50};
  localparam int EXP_T [NV] = '{0, 3, 8, 18, 50, 80, 127, 127};
  localparam bit OVR_T [NV] = '{0, 0, 0, 0, 0, 0, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp;
  logic sw_az, sw_in, sw_ref, busy, done, ovr;
  logic [W-1:0] result;

  int checks = 0;
  int fails = 0;
  int vin = 0;
  int integ;
  int az_tot = 0, in_tot = 0, bbm_bad = 0;
  logic [2:0] sw_prev = 3'b000;

  always #2 clk = ~clk;

  dsadc_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp),
    .sw_az_o(sw_az), .sw_in_o(sw_in), .sw_ref_o(sw_ref),
    .busy_o(busy), .done_o(done), .ovr_o(ovr), .result_o(result)
  );

  // behavioural integrator: offset nulled in auto-zero, input up, fixed reference down
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      integ <= 3;
    else if (sw_az)  integ <= 0;
    else if (sw_in)  integ <= integ + vin;
    else if (sw_ref) integ <= integ - REF_STEP;
  end
  assign cmp = (integ > 0);

  // phase-length and break-before-make monitor (cumulative)
  always_ff @(posedge clk) begin
    if (rst_n) begin
      az_tot <= az_tot + int'(sw_az);
      in_tot <= in_tot + int'(sw_in);
      if ($countones({sw_az, sw_in, sw_ref}) > 1 ||
          ({sw_az, sw_in, sw_ref} != 3'b000 && sw_prev != 3'b000 &&
           {sw_az, sw_in, sw_ref} != sw_prev))
        bbm_bad <= bbm_bad + 1;
      sw_prev <= {sw_az, sw_in, sw_ref};
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic run_conv(input int v, input int exp_res, input bit exp_ovr,
                          input bit mid_start);
    int az0, in0, bad0, n;
    @(negedge clk);
    vin = v;
    az0 = az_tot; in0 = in_tot; bad0 = bbm_bad;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(sw_az == 1'b1, "R2 az after start", int'(sw_az), 1);
    chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    if (mid_start) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R7 done reached", int'(done), 1);
    if (n >= 2000) finish_run();
    chk(result == W'(exp_res), "R5 R6 result", int'(result), exp_res);
    chk(ovr == exp_ovr, "R6 ovr flag", int'(ovr), int'(exp_ovr));
    chk(az_tot - az0 == AZ, "R2 az length", az_tot - az0, AZ);
    chk(in_tot - in0 == INT, "R3 int length", in_tot - in0, INT);
    chk(bbm_bad == bad0, "R4 break-before-make", bbm_bad - bad0, 0);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
    chk(busy == 1'b0, "R8 busy low after done", int'(busy), 0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({sw_az, sw_in, sw_ref, busy, done, ovr} == 6'b0, "R1 ctl in reset",
        int'({sw_az, sw_in, sw_ref, busy, done, ovr}), 0);
    chk(result == '0, "R1 result in reset", int'(result), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({sw_az, sw_in, sw_ref, busy, done, ovr} == 6'b0, "R1 ctl after reset",
        int'({sw_az, sw_in, sw_ref, busy, done, ovr}), 0);

    for (int i = 0; i < NV; i++)
      run_conv(VIN_T[i], EXP_T[i], OVR_T[i], 1'b0);

    // R7: result held while idle and during the next conversion
    run_conv(7, 18, 1'b0, 1'b0);
    vin = 30;
    repeat (10) @(negedge clk);
    chk(result == W'(18), "R7 hold idle", int'(result), 18);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (AZ + INT + 5) @(negedge clk);
    chk(result == W'(18) && !ovr, "R7 hold mid-conversion", int'(result), 18);
    while (!done) @(negedge clk);
    chk(result == W'(75), "R5 result after hold", int'(result), 75);
    @(negedge clk);

    // R9: start during auto-zero ignored, no queued conversion
    run_conv(3, 8, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    chk(busy == 1'b0 && sw_az == 1'b0, "R9 no queued start", int'(busy), 0);

    // R6: overrange cleared by following in-range conversion
    run_conv(60, 127, 1'b1, 1'b0);
    run_conv(32, 80, 1'b0, 1'b0);

    finish_run();
  end
endmodule